// File: doc/BRIEF.md
# Flash Portal Command Controller

This block lets a local processor issue one flash operation at a time (read, write or erase) to a shared SPI flash engine. Software writes a flash address, a buffer address and a command word through a small register port, then writes a start strobe. The controller vets the command before anything leaves the block. It checks the operation type, the byte count of a read or write, and whether an erase size is actually supported. Only a valid command becomes a request on the downstream request/acknowledge port.

While a request is outstanding, a busy flag is raised and further start strobes are refused. Completion and every refusal are recorded in a sticky status register. Each status bit is cleared by writing 1 to it. A done interrupt is produced from the done bit and an enable bit. The supported erase sizes come from a capability bitmap. The block forms this bitmap as the bitwise AND of the capability bits of each attached flash device, so a size is offered only when every device has it.

Top module: `flash_portal_ctrl`

## Requirements
- R1: After reset, busy_o, eng_req and irq_o are 0, and the status register (word 4) and the interrupt enable (word 5) read as 0.
- R2: The command word holds the operation in bits [1:0]: 0 read, 1 write, 2 erase. Value 3 is refused. A refusal sets status bit 1 (bad request) and status bit 0 (done) in the same cycle, and no request is issued.
- R3: For read and write, the size field in command bits [8+LEN_W-1:8] must be between 1 and MAX_LEN (64) inclusive. Any other value is refused as in R2.
- R4: For erase, the size field is an encoding: 0 is 4 KB, 1 is 32 KB, 2 is 64 KB. erase_caps_o bit i is the AND over all devices of dev_erase_caps bit i, where device d occupies bits [3d+2:3d]. An erase is accepted only if the encoding is below 3 and its bit in erase_caps_o is 1. Otherwise it is refused as in R2.
- R5: A write of 1 in bit 0 to word 3 is a start strobe; a write of 0 does nothing. For an accepted start, busy_o and eng_req become 1 one cycle after the strobe. eng_op, eng_len, eng_flash_addr and eng_buf_addr carry the values captured at the strobe, and they hold steady until eng_ack.
- R6: A start strobe while busy_o is 1 is refused. It sets only status bit 3, without done, and leaves the outstanding request and its fields unchanged.
- R7: A start strobe while share_en is 0 is refused. It sets status bit 4 and done, and issues no request.
- R8: eng_ack while busy clears busy_o and eng_req and sets done on the same edge. If eng_err is 1 with eng_ack, status bit 2 is also set.
- R9: Writing to word 4 clears exactly the status bits written as 1. The other bits keep their value.
- R10: irq_o is 1 exactly when done is 1 and bit 0 of word 5 (interrupt enable) is 1.
- R11: Words 0, 1 and 2 read back the flash address, the buffer address and the stored operation and size fields (other bits 0). Word 6 bit 0 reads busy. Word 3 reads 0.
- R12: eng_ack while not busy has no effect on status or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| share_en | input | 1 | Flash sharing enabled; starts are refused while low |
| dev_erase_caps | input | 3*NUM_DEV | Per-device erase size support, 3 bits per device |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| busy_o | output | 1 | A request is outstanding |
| erase_caps_o | output | 3 | Erase sizes supported by all devices |
| irq_o | output | 1 | Done interrupt |
| eng_req | output | 1 | Request to flash engine, held until acknowledge |
| eng_op | output | 2 | Operation of the outstanding request |
| eng_len | output | LEN_W | Byte count, or erase encoding |
| eng_flash_addr | output | FADDR_W | Flash address of the request |
| eng_buf_addr | output | BADDR_W | Buffer address of the request |
| eng_ack | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error, valid with eng_ack |

## Verification
On every cycle, the assertions check that an outstanding request never carries operation 3, an out-of-range byte count or an unsupported erase size. They also check that a request and its fields hold until acknowledged, that busy rises only after a start strobe, that done is present whenever busy falls, and that the interrupt never fires without done and enable. The bench sweeps every operation and every size value for read and write, and every pair of device capability patterns against every erase encoding. Only those scenarios show the exact refusal bits, refusal while busy or while sharing is off, clear-on-one behaviour, readback, and that an idle acknowledge is ignored.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_ERASE = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   localparam int ST_DONE    = 0;
   localparam int ST_BADREQ  = 1;
   localparam int ST_ENGERR  = 2;
   localparam int ST_BUSYREJ = 3;
   localparam int ST_OFFREJ  = 4;
   localparam int ST_W       = 5;

   localparam int RADDR_W     = 3;
   localparam int RDATA_W     = 32;
   localparam int CMD_LEN_LSB = 8;
   localparam int ERASE_SIZES = 3;

   localparam logic [RADDR_W-1:0] RA_FLASH  = 3'd0;
   localparam logic [RADDR_W-1:0] RA_BUF    = 3'd1;
   localparam logic [RADDR_W-1:0] RA_CMD    = 3'd2;
   localparam logic [RADDR_W-1:0] RA_START  = 3'd3;
   localparam logic [RADDR_W-1:0] RA_STATUS = 3'd4;
   localparam logic [RADDR_W-1:0] RA_IRQEN  = 3'd5;
   localparam logic [RADDR_W-1:0] RA_BUSY   = 3'd6;
endpackage

// File: rtl/fpc_caps.sv
module fpc_caps #(
   parameter int NUM_DEV = 2,
   localparam int CW = fpc_pkg::ERASE_SIZES
) (
   input  logic [NUM_DEV*CW-1:0] dev_caps,
   output logic [CW-1:0]         cap_map
);
   generate
      if (NUM_DEV == 1) begin : g_single
         assign cap_map = dev_caps;
      end else begin : g_multi
         always_comb begin
            cap_map = '1;
            for (int d = 0; d < NUM_DEV; d++) begin
               cap_map = cap_map & dev_caps[d*CW +: CW];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fpc_validate.sv
module fpc_validate #(
   parameter int LEN_W   = 7,
   parameter int MAX_LEN = 64
) (
   input  fpc_pkg::op_e                     op,
   input  logic [LEN_W-1:0]                 len,
   input  logic [fpc_pkg::ERASE_SIZES-1:0]  caps,
   output logic                             ok
);
   import fpc_pkg::*;
   logic [3:0] cap4;

   assign cap4 = {1'b0, caps};

   always_comb begin
      unique case (op)
         OP_READ, OP_WRITE: ok = (len != '0) && (len <= LEN_W'(MAX_LEN));
         OP_ERASE:          ok = (len < LEN_W'(ERASE_SIZES)) && cap4[len[1:0]];
         default:           ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpc_regs.sv
module fpc_regs #(
   parameter int FADDR_W = 32,
   parameter int BADDR_W = 32,
   parameter int LEN_W   = 7
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [fpc_pkg::RADDR_W-1:0]         wr_addr,
   input  logic [fpc_pkg::RDATA_W-1:0]         wr_data,
   output logic [FADDR_W-1:0]                  flash_q,
   output logic [BADDR_W-1:0]                  buf_q,
   output fpc_pkg::op_e                        op_q,
   output logic [LEN_W-1:0]                    len_q,
   output logic                                irq_en_q,
   output logic                                start_o,
   output logic                                clr_en_o,
   output logic [fpc_pkg::ST_W-1:0]            clr_mask_o
);
   import fpc_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flash_q  <= '0;
         buf_q    <= '0;
         op_q     <= OP_READ;
         len_q    <= '0;
         irq_en_q <= 1'b0;
      end else if (wr_en) begin
         unique case (wr_addr)
            RA_FLASH: flash_q <= wr_data[FADDR_W-1:0];
            RA_BUF:   buf_q   <= wr_data[BADDR_W-1:0];
            RA_CMD: begin
               op_q  <= op_e'(wr_data[1:0]);
               len_q <= wr_data[CMD_LEN_LSB +: LEN_W];
            end
            RA_IRQEN: irq_en_q <= wr_data[0];
            default: ;
         endcase
      end
   end

   assign start_o    = wr_en && (wr_addr == RA_START) && wr_data[0];
   assign clr_en_o   = wr_en && (wr_addr == RA_STATUS);
   assign clr_mask_o = wr_data[ST_W-1:0];
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq #(
   parameter int FADDR_W = 32,
   parameter int BADDR_W = 32,
   parameter int LEN_W   = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      share_en,
   input  logic                      req_ok,
   input  fpc_pkg::op_e              op_in,
   input  logic [LEN_W-1:0]          len_in,
   input  logic [FADDR_W-1:0]        flash_in,
   input  logic [BADDR_W-1:0]        buf_in,
   input  logic                      clr_en,
   input  logic [fpc_pkg::ST_W-1:0]  clr_mask,
   input  logic                      ack,
   input  logic                      err,
   output logic                      busy_q,
   output logic [fpc_pkg::ST_W-1:0]  status_q,
   output fpc_pkg::op_e              op_q,
   output logic [LEN_W-1:0]          len_q,
   output logic [FADDR_W-1:0]        flash_q,
   output logic [BADDR_W-1:0]        buf_q
);
   import fpc_pkg::*;
   logic [ST_W-1:0] set_v;
   logic            launch;
   logic            finish;

   always_comb begin
      set_v  = '0;
      launch = 1'b0;
      finish = busy_q && ack;
      if (start) begin
         if (busy_q) begin
            set_v[ST_BUSYREJ] = 1'b1;
         end else if (!share_en) begin
            set_v[ST_OFFREJ] = 1'b1;
            set_v[ST_DONE]   = 1'b1;
         end else if (!req_ok) begin
            set_v[ST_BADREQ] = 1'b1;
            set_v[ST_DONE]   = 1'b1;
         end else begin
            launch = 1'b1;
         end
      end
      if (finish) begin
         set_v[ST_DONE]   = 1'b1;
         set_v[ST_ENGERR] = err;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         status_q <= '0;
         op_q     <= OP_READ;
         len_q    <= '0;
         flash_q  <= '0;
         buf_q    <= '0;
      end else begin
         status_q <= (status_q & ~(clr_en ? clr_mask : '0)) | set_v;
         if (launch) begin
            busy_q  <= 1'b1;
            op_q    <= op_in;
            len_q   <= len_in;
            flash_q <= flash_in;
            buf_q   <= buf_in;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/flash_portal_ctrl.sv
module flash_portal_ctrl #(
   parameter int NUM_DEV = 2,
   parameter int LEN_W   = 7,
   parameter int MAX_LEN = 64,
   parameter int FADDR_W = 32,
   parameter int BADDR_W = 32,
   localparam int CW = fpc_pkg::ERASE_SIZES
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          share_en,
   input  logic [NUM_DEV*CW-1:0]         dev_erase_caps,
   input  logic                          reg_wr_en,
   input  logic [fpc_pkg::RADDR_W-1:0]   reg_wr_addr,
   input  logic [fpc_pkg::RDATA_W-1:0]   reg_wr_data,
   input  logic [fpc_pkg::RADDR_W-1:0]   reg_rd_addr,
   output logic [fpc_pkg::RDATA_W-1:0]   reg_rd_data,
   output logic                          busy_o,
   output logic [CW-1:0]                 erase_caps_o,
   output logic                          irq_o,
   output logic                          eng_req,
   output logic [1:0]                    eng_op,
   output logic [LEN_W-1:0]              eng_len,
   output logic [FADDR_W-1:0]            eng_flash_addr,
   output logic [BADDR_W-1:0]            eng_buf_addr,
   input  logic                          eng_ack,
   input  logic                          eng_err
);
   import fpc_pkg::*;

   generate
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("NUM_DEV must be at least 1");
      end
      if (MAX_LEN < 1 || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("MAX_LEN must be 1 .. 2**LEN_W-1");
      end
      if (LEN_W < 2 || CMD_LEN_LSB + LEN_W > RDATA_W) begin : g_bad_lw
         $error("LEN_W does not fit the command word");
      end
      if (FADDR_W > RDATA_W || BADDR_W > RDATA_W) begin : g_bad_aw
         $error("address widths exceed the register width");
      end
   endgenerate

   logic [FADDR_W-1:0] flash_r;
   logic [BADDR_W-1:0] buf_r;
   op_e                op_r;
   logic [LEN_W-1:0]   len_r;
   logic               irq_en_q;
   logic               start;
   logic               clr_en;
   logic [ST_W-1:0]    clr_mask;
   logic               req_ok;
   logic               busy_q;
   logic [ST_W-1:0]    status_q;
   op_e                eng_op_e;

   fpc_regs #(.FADDR_W(FADDR_W), .BADDR_W(BADDR_W), .LEN_W(LEN_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .flash_q(flash_r), .buf_q(buf_r), .op_q(op_r), .len_q(len_r),
      .irq_en_q(irq_en_q), .start_o(start),
      .clr_en_o(clr_en), .clr_mask_o(clr_mask)
   );

   fpc_caps #(.NUM_DEV(NUM_DEV)) i_caps (
      .dev_caps(dev_erase_caps), .cap_map(erase_caps_o)
   );

   fpc_validate #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) i_val (
      .op(op_r), .len(len_r), .caps(erase_caps_o), .ok(req_ok)
   );

   fpc_seq #(.FADDR_W(FADDR_W), .BADDR_W(BADDR_W), .LEN_W(LEN_W)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .start(start), .share_en(share_en), .req_ok(req_ok),
      .op_in(op_r), .len_in(len_r), .flash_in(flash_r), .buf_in(buf_r),
      .clr_en(clr_en), .clr_mask(clr_mask),
      .ack(eng_ack), .err(eng_err),
      .busy_q(busy_q), .status_q(status_q),
      .op_q(eng_op_e), .len_q(eng_len),
      .flash_q(eng_flash_addr), .buf_q(eng_buf_addr)
   );

   assign busy_o  = busy_q;
   assign eng_req = busy_q;
   assign eng_op  = eng_op_e;
   assign irq_o   = status_q[ST_DONE] & irq_en_q;

   always_comb begin
      reg_rd_data = '0;
      unique case (reg_rd_addr)
         RA_FLASH:  reg_rd_data[FADDR_W-1:0] = flash_r;
         RA_BUF:    reg_rd_data[BADDR_W-1:0] = buf_r;
         RA_CMD: begin
            reg_rd_data[1:0]                  = op_r;
            reg_rd_data[CMD_LEN_LSB +: LEN_W] = len_r;
         end
         RA_STATUS: reg_rd_data[ST_W-1:0] = status_q;
         RA_IRQEN:  reg_rd_data[0] = irq_en_q;
         RA_BUSY:   reg_rd_data[0] = busy_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
   parameter int LEN_W   = 7,
   parameter int MAX_LEN = 64,
   parameter int FADDR_W = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         reg_wr_en,
   input logic [fpc_pkg::RADDR_W-1:0]  reg_wr_addr,
   input logic [fpc_pkg::RDATA_W-1:0]  reg_wr_data,
   input logic                         busy_o,
   input logic                         eng_req,
   input logic [1:0]                   eng_op,
   input logic [LEN_W-1:0]             eng_len,
   input logic [FADDR_W-1:0]           eng_flash_addr,
   input logic [2:0]                   erase_caps_o,
   input logic                         eng_ack,
   input logic                         irq_o,
   input logic [fpc_pkg::ST_W-1:0]     status,
   input logic                         irq_en
);
   logic strobe;
   logic [3:0] cap4;
   assign strobe = reg_wr_en && (reg_wr_addr == fpc_pkg::RA_START) && reg_wr_data[0];
   assign cap4   = {1'b0, erase_caps_o};

   // R2
   op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> (eng_op != 2'd3));
   // R3
   rw_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_op != 2'd2) |-> (eng_len != '0 && eng_len <= LEN_W'(MAX_LEN)));
   // R4
   erase_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_op == 2'd2) |-> (eng_len < LEN_W'(3) && cap4[eng_len[1:0]]));
   // R5
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(strobe));
   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_len)
                                 && $stable(eng_flash_addr)));
   // R6
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && strobe && !eng_ack) |=> busy_o);
   // R8
   done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> status[fpc_pkg::ST_DONE]);
   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status[fpc_pkg::ST_DONE] && irq_en));
endmodule

bind flash_portal_ctrl fpc_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .FADDR_W(FADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n),
   .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
   .busy_o(busy_o), .eng_req(eng_req), .eng_op(eng_op), .eng_len(eng_len),
   .eng_flash_addr(eng_flash_addr), .erase_caps_o(erase_caps_o),
   .eng_ack(eng_ack), .irq_o(irq_o), .status(status_q), .irq_en(irq_en_q)
);

// File: tb/test_flash_portal_ctrl.sv
module test_flash_portal_ctrl;
   localparam int NUM_DEV = 2;
   localparam int LEN_W   = 7;
   localparam int MAX_LEN = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        share_en = 1'b0;
   logic [5:0]  dev_caps = 6'b111111;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        busy;
   logic [2:0]  caps;
   logic        irq;
   logic        req;
   logic [1:0]  eop;
   logic [LEN_W-1:0] elen;
   logic [31:0] efa;
   logic [31:0] eba;
   logic        ack = 1'b0;
   logic        err = 1'b0;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   flash_portal_ctrl #(.NUM_DEV(NUM_DEV), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) i_flash_portal_ctrl (
      .clk(clk), .rst_n(rst_n), .share_en(share_en), .dev_erase_caps(dev_caps),
      .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
      .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
      .busy_o(busy), .erase_caps_o(caps), .irq_o(irq),
      .eng_req(req), .eng_op(eop), .eng_len(elen),
      .eng_flash_addr(efa), .eng_buf_addr(eba),
      .eng_ack(ack), .eng_err(err)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic pulse_ack(input logic e);
      @(negedge clk);
      ack = 1'b1; err = e;
      @(posedge clk);
      @(negedge clk);
      ack = 1'b0; err = 1'b0;
   endtask

   // issue one command and check acceptance or refusal
   task automatic run(input string rq, input int op, input int len, input logic ok);
      logic [31:0] v;
      wr(3'd4, 32'h1F);
      wr(3'd2, (len << 8) | op);
      wr(3'd3, 32'h1);
      check(rq, {31'b0, busy}, {31'b0, ok});
      rd(3'd4, v);
      check(rq, v, ok ? 32'h0 : 32'h3);
      if (ok) begin
         check(rq, {30'b0, eop}, op);
         check(rq, {25'b0, elen}, len);
         pulse_ack(1'b0);
         check("R8", {31'b0, busy}, 32'h0);
         rd(3'd4, v);
         check("R8", v, 32'h1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1", {29'b0, busy, req, irq}, 32'h0);
      rd(3'd4, v); check("R1", v, 32'h0);
      rd(3'd5, v); check("R1", v, 32'h0);
      share_en = 1'b1;

      // R11 readback
      wr(3'd0, 32'h0012_3400);
      wr(3'd1, 32'hA000_0040);
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd0, v); check("R11", v, 32'h0012_3400);
      rd(3'd1, v); check("R11", v, 32'hA000_0040);
      rd(3'd2, v); check("R11", v, 32'h0000_7F03);
      rd(3'd3, v); check("R11", v, 32'h0);

      // R3 sweep of every size for read and write
      for (int op = 0; op < 2; op++)
         for (int len = 0; len < 128; len++)
            run("R3", op, len, (len >= 1) && (len <= MAX_LEN));

      // R2 reserved operation
      for (int len = 0; len < 128; len += 9)
         run("R2", 3, len, 1'b0);

      // R4 all capability pairs against erase encodings
      for (int c0 = 0; c0 < 8; c0++)
         for (int c1 = 0; c1 < 8; c1++) begin
            dev_caps = {c1[2:0], c0[2:0]};
            #0.5;
            check("R4", {29'b0, caps}, c0 & c1);
            for (int e = 0; e < 5; e++) begin
               int enc;
               int m;
               enc = (e == 4) ? 7 : e;
               m = c0 & c1;
               run("R4", 2, enc, (enc < 3) && m[enc]);
            end
         end
      dev_caps = 6'b111111;

      // R5 start strobe with bit 0 clear does nothing
      wr(3'd4, 32'h1F);
      wr(3'd2, 32'h0000_0400);
      wr(3'd3, 32'h2);
      check("R5", {31'b0, busy}, 32'h0);
      rd(3'd4, v); check("R5", v, 32'h0);

      // R5 captured fields, R6 start while busy
      wr(3'd3, 32'h1);
      check("R5", {31'b0, req}, 32'h1);
      check("R5", efa, 32'h0012_3400);
      check("R5", eba, 32'hA000_0040);
      wr(3'd2, 32'h0000_0901);
      wr(3'd0, 32'h0000_5000);
      wr(3'd3, 32'h1);
      check("R6", {31'b0, busy}, 32'h1);
      rd(3'd4, v); check("R6", v, 32'h8);
      check("R6", {30'b0, eop}, 32'h0);
      check("R6", {25'b0, elen}, 32'h4);
      check("R6", efa, 32'h0012_3400);
      // R8 error with acknowledge
      pulse_ack(1'b1);
      check("R8", {31'b0, req}, 32'h0);
      rd(3'd4, v); check("R8", v, 32'hD);

      // R9 clear on one
      wr(3'd4, 32'h4);
      rd(3'd4, v); check("R9", v, 32'h9);
      wr(3'd4, 32'h9);
      rd(3'd4, v); check("R9", v, 32'h0);

      // R7 sharing off
      share_en = 1'b0;
      wr(3'd3, 32'h1);
      check("R7", {31'b0, busy}, 32'h0);
      rd(3'd4, v); check("R7", v, 32'h11);
      share_en = 1'b1;

      // R10 interrupt gating
      check("R10", {31'b0, irq}, 32'h0);
      wr(3'd5, 32'h1);
      check("R10", {31'b0, irq}, 32'h1);
      rd(3'd5, v); check("R10", v, 32'h1);
      wr(3'd4, 32'h1F);
      check("R10", {31'b0, irq}, 32'h0);

      // R12 acknowledge while idle
      pulse_ack(1'b1);
      check("R12", {31'b0, busy}, 32'h0);
      rd(3'd4, v); check("R12", v, 32'h0);
      rd(3'd6, v); check("R11", v, 32'h0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule